// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block paces auto-refresh requests for an SDRAM controller. Rather than
issuing every refresh of a retention period in one burst, a free-running
interval timer produces one refresh obligation per interval. For example, an
array of 8192 rows with a 64 ms retention needs one refresh roughly every
7.8 us. The interval is a parameter in clock cycles. It may be set shorter
than nominal for margin. No row address is tracked, because the memory
advances its own internal row pointer on each auto-refresh.

Obligations that the controller has not yet served collect in a bounded debt
counter. The controller sees a request whenever debt is outstanding, and it
acknowledges each auto-refresh it issues with a one-cycle pulse. A busy
controller may let debt build up to a fixed postponement limit (8 by default)
and then clear it back to back. At the limit the block raises an urgent
signal, and the controller must then refresh before issuing any other
command. If one more interval expires while the debt is already at the limit,
a sticky overflow flag records the integrity violation until reset.

Top module: `refresh_pacer`

## Requirements
- R1: While and after synchronous active-low reset, pending_count is 0, refresh_req, refresh_urgent and refresh_overflow are 0, and the interval timer restarts from zero elapsed cycles.
- R2: With no acknowledges, pending_count first becomes 1 after the INTERVAL-th rising edge following reset release, and it rises by one every INTERVAL edges after that.
- R3: refresh_req is 1 exactly when pending_count is nonzero.
- R4: refresh_urgent is 1 exactly when pending_count equals LIMIT, and pending_count never exceeds LIMIT.
- R5: A refresh_ack sampled high while pending_count is nonzero, with no interval expiry on that edge, lowers pending_count by one at that edge.
- R6: A refresh_ack sampled while pending_count is 0 is ignored: the count stays 0 and does not wrap.
- R7: An interval expiry while pending_count equals LIMIT, with no accepted ack on that edge, leaves the count at LIMIT and sets refresh_overflow.
- R8: refresh_overflow stays set until reset, however the count later changes.
- R9: An expiry and an accepted ack on the same edge cancel: the count is unchanged, and no overflow is raised even at LIMIT.
- R10: Acknowledges never restart or shift the interval timer; expiries stay on the INTERVAL grid set by reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| refresh_ack | input | 1 | One-cycle pulse per auto-refresh issued by the controller |
| refresh_req | output | 1 | At least one refresh is owed |
| refresh_urgent | output | 1 | Debt is at the postponement limit; refresh first |
| refresh_overflow | output | 1 | Sticky: an interval expired with the debt already at the limit |
| pending_count | output | $clog2(LIMIT+1) | Number of refreshes currently owed |

## Verification
On every cycle the assertions check that the count stays within LIMIT and moves by at most one step, that urgency implies a request, that overflow can only rise out of the urgent state and never falls outside reset, and that an ack with no debt cannot make the count wrap. Only the bench's scenarios can show the absolute timing of expiries after reset release, that acks leave the timer phase untouched, and that a simultaneous ack and expiry at the limit cancel without an overflow. These require the cycle-accurate reference model run alongside the design with idle, drained, saturated and pseudo-random acknowledge patterns.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;

   // Decision taken by the debt ledger on each clock edge.
   typedef enum logic [1:0] {
      LEDGER_HOLD = 2'd0,
      LEDGER_INC  = 2'd1,
      LEDGER_DEC  = 2'd2,
      LEDGER_OVF  = 2'd3
   } ledger_op_e;

   // An expiry adds one obligation, an accepted ack removes one; both cancel.
   function automatic ledger_op_e pick_ledger_op(input logic expire,
                                                 input logic ack_ok,
                                                 input logic at_limit);
      ledger_op_e op;
      op = LEDGER_HOLD;
      if (expire && !ack_ok)
         op = at_limit ? LEDGER_OVF : LEDGER_INC;
      else if (!expire && ack_ok)
         op = LEDGER_DEC;
      return op;
   endfunction

endpackage

// File: rtl/refresh_pacer_timer.sv
module refresh_pacer_timer #(
   parameter int INTERVAL   = 1560,
   parameter bit COUNT_DOWN = 1'b0,
   localparam int TW        = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire
);

   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("refresh_pacer_timer: INTERVAL must be at least 2");
      end

      if (COUNT_DOWN) begin : g_down
         // Remaining cycles until expiry; reset loads the full interval.
         logic [TW-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)
               remain <= LAST;
            else if (remain == '0)
               remain <= LAST;
            else
               remain <= remain - 1'b1;
         end
         assign expire = (remain == '0);
      end else begin : g_up
         // Elapsed cycles since the last expiry; reset clears it.
         logic [TW-1:0] elapsed;
         always_ff @(posedge clk) begin
            if (!rst_n)
               elapsed <= '0;
            else if (elapsed == LAST)
               elapsed <= '0;
            else
               elapsed <= elapsed + 1'b1;
         end
         assign expire = (elapsed == LAST);
      end
   endgenerate

endmodule

// File: rtl/refresh_pacer_ledger.sv
module refresh_pacer_ledger
   import refresh_pacer_pkg::*;
#(
   parameter int LIMIT  = 8,
   localparam int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          expire,
   input  logic          ack,
   output logic [CW-1:0] debt,
   output logic          at_limit,
   output logic          overflow
);

   localparam logic [CW-1:0] CAP = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("refresh_pacer_ledger: LIMIT must be at least 1");
      end
   endgenerate

   logic       ack_ok;
   ledger_op_e op;

   assign at_limit = (debt == CAP);
   assign ack_ok   = ack && (debt != '0);
   assign op       = pick_ledger_op(expire, ack_ok, at_limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         debt     <= '0;
         overflow <= 1'b0;
      end else begin
         unique case (op)
            LEDGER_INC:  debt <= debt + 1'b1;
            LEDGER_DEC:  debt <= debt - 1'b1;
            LEDGER_OVF:  overflow <= 1'b1;
            default:     debt <= debt;
         endcase
      end
   end

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
   import refresh_pacer_pkg::*;
#(
   parameter int INTERVAL   = 1560,
   parameter int LIMIT      = 8,
   parameter bit COUNT_DOWN = 1'b0,
   localparam int CW        = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          refresh_ack,
   output logic          refresh_req,
   output logic          refresh_urgent,
   output logic          refresh_overflow,
   output logic [CW-1:0] pending_count
);

   logic expire;
   logic at_limit;

   refresh_pacer_timer #(
      .INTERVAL   (INTERVAL),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire)
   );

   refresh_pacer_ledger #(
      .LIMIT (LIMIT)
   ) u_ledger (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .ack      (refresh_ack),
      .debt     (pending_count),
      .at_limit (at_limit),
      .overflow (refresh_overflow)
   );

   assign refresh_req    = (pending_count != '0);
   assign refresh_urgent = at_limit;

endmodule

// File: rtl/refresh_pacer_chk.sv
module refresh_pacer_chk #(
   parameter int LIMIT = 8,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          refresh_ack,
   input logic          refresh_req,
   input logic          refresh_urgent,
   input logic          refresh_overflow,
   input logic [CW-1:0] pending_count
);

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pending_count) <= LIMIT);

   assert_urgent_implies_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_urgent |-> refresh_req);

   assert_req_tracks_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_count == '0) |-> !refresh_req);

   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pending_count) |->
         (int'(pending_count) == int'($past(pending_count)) + 1) ||
         (int'(pending_count) == int'($past(pending_count)) - 1));

   assert_no_wrap_on_idle_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_count == '0 && refresh_ack) |=> int'(pending_count) <= 1);

   assert_overflow_from_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_overflow) |-> $past(refresh_urgent));

   assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_overflow |=> refresh_overflow);

endmodule

bind refresh_pacer refresh_pacer_chk #(.LIMIT(LIMIT)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .refresh_ack      (refresh_ack),
   .refresh_req      (refresh_req),
   .refresh_urgent   (refresh_urgent),
   .refresh_overflow (refresh_overflow),
   .pending_count    (pending_count)
);

// File: tb/refresh_pacer_bench.sv
`timescale 1ns/1ps
module refresh_pacer_bench;

   localparam int INTERVAL = 12;
   localparam int LIMIT    = 3;
   localparam int CW       = $clog2(LIMIT + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          refresh_ack = 1'b0;
   logic          refresh_req;
   logic          refresh_urgent;
   logic          refresh_overflow;
   logic [CW-1:0] pending_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   // Behavioural reference state.
   int m_phase = 0;
   int m_debt  = 0;
   bit m_ovf   = 1'b0;

   always #2.5 clk = ~clk;

   refresh_pacer #(.INTERVAL(INTERVAL), .LIMIT(LIMIT)) u_refresh_pacer (
      .clk              (clk),
      .rst_n            (rst_n),
      .refresh_ack      (refresh_ack),
      .refresh_req      (refresh_req),
      .refresh_urgent   (refresh_urgent),
      .refresh_overflow (refresh_overflow),
      .pending_count    (pending_count)
   );

   // Reference model: advanced on each rising edge from the sampled inputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0;
         m_debt  = 0;
         m_ovf   = 1'b0;
      end else begin
         bit fire;
         bit take;
         fire = (m_phase == INTERVAL - 1);
         m_phase = fire ? 0 : m_phase + 1;
         take = refresh_ack && (m_debt > 0);
         if (fire && !take) begin
            if (m_debt == LIMIT) m_ovf = 1'b1;
            else m_debt = m_debt + 1;
         end else if (!fire && take) begin
            m_debt = m_debt - 1;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Every-cycle comparison against the model, away from the rising edge.
   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         check("R2/R5 pending_count vs model", int'(pending_count), m_debt);
         check("R3 refresh_req vs model", int'(refresh_req), int'(m_debt != 0));
         check("R4 refresh_urgent vs model", int'(refresh_urgent), int'(m_debt == LIMIT));
         check("R7 refresh_overflow vs model", int'(refresh_overflow), int'(m_ovf));
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      refresh_ack = 1'b0;
      wait_cycles(3);
      rst_n = 1'b1;
   endtask

   task automatic pulse_ack();
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
   endtask

   // Wait until the next rising edge is an expiry edge.
   task automatic align_to_expiry();
      while (m_phase != INTERVAL - 1) @(negedge clk);
   endtask

   initial begin
      // R1: reset state.
      wait_cycles(3);
      check("R1 count in reset", int'(pending_count), 0);
      check("R1 req in reset", int'(refresh_req), 0);
      check("R1 overflow in reset", int'(refresh_overflow), 0);
      rst_n = 1'b1;

      // R2: first expiry after INTERVAL edges.
      wait_cycles(INTERVAL - 1);
      check("R2 no request before first interval", int'(pending_count), 0);
      wait_cycles(1);
      check("R2 first request after interval", int'(pending_count), 1);
      check("R3 req with debt", int'(refresh_req), 1);

      // R5: ack decrements.
      pulse_ack();
      check("R5 ack clears debt", int'(pending_count), 0);
      // R6: ack at zero ignored.
      pulse_ack();
      check("R6 ack at zero ignored", int'(pending_count), 0);
      check("R6 no request after idle ack", int'(refresh_req), 0);

      // R10: acks did not shift the grid; next expiry is at 2*INTERVAL.
      wait_cycles(INTERVAL - 3);
      check("R10 no expiry before grid point", int'(pending_count), 0);
      wait_cycles(1);
      check("R10 expiry on grid point", int'(pending_count), 1);

      // R4: build debt to the limit.
      wait_cycles((LIMIT - 1) * INTERVAL);
      check("R4 debt reaches limit", int'(pending_count), LIMIT);
      check("R4 urgent at limit", int'(refresh_urgent), 1);

      // R7: one more expiry at the limit.
      wait_cycles(INTERVAL);
      check("R7 count held at limit", int'(pending_count), LIMIT);
      check("R7 overflow set", int'(refresh_overflow), 1);

      // R8: drain back to back; overflow stays.
      for (int k = 0; k < LIMIT; k++) begin
         if (m_phase == INTERVAL - 1) @(negedge clk);
         pulse_ack();
      end
      check("R8 drained", int'(pending_count), 0);
      check("R8 overflow sticky", int'(refresh_overflow), 1);
      check("R4 urgent cleared after drain", int'(refresh_urgent), 0);

      // R1/R8: reset clears overflow.
      do_reset();
      @(negedge clk);
      check("R8 reset clears overflow", int'(refresh_overflow), 0);

      // R9: ack and expiry on the same edge at the limit.
      wait_cycles(LIMIT * INTERVAL);
      check("R9 setup at limit", int'(pending_count), LIMIT);
      align_to_expiry();
      pulse_ack();
      check("R9 count unchanged", int'(pending_count), LIMIT);
      check("R9 no overflow", int'(refresh_overflow), 0);

      // Pseudo-random acknowledge pattern, model compared every cycle.
      begin
         logic [7:0] lfsr = 8'hA5;
         for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            refresh_ack = (lfsr[2:0] == 3'b000);
            @(negedge clk);
         end
         refresh_ack = 1'b0;
      end
      wait_cycles(2);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule